// File: doc/BRIEF.md
# Strap-Configured External Bus Width Adapter

This block connects a 32-bit internal load/store port to an external memory bus. The bus is either 32 or 16 bits wide. The width comes from a strap input, and the block captures it only while reset is held. The internal side presents an address, a transfer size (byte, halfword or word), a direction flag and write data, all with a one-cycle request strobe. The external side gets a word address, four active-low byte-select pins, the write data with lane-pair output enables, and a data-phase indication that stays up until the memory answers with ready.

In 16-bit mode, two of the byte-select pins take on new meanings: one carries address bit 1 and one carries the high-byte enable. The upper sixteen data lines are never driven in this mode. A word transfer is split into two halfword cycles, and the read result is assembled from both halves. Some requests never reach the bus: misaligned requests and requests into the on-chip I/O window (address top two bits `11`). Both are answered in one cycle, and misaligned requests also raise an error flag.

Top module: `bsz_bus_sizer`

## Requirements
- R1: The strap is captured on every clock edge while `rst_n` is low. A value of 0 selects 32-bit mode and 1 selects 16-bit mode. Strap changes after reset is released have no effect on the mode.
- R2: In 32-bit mode, a byte at address offset k drives only `bus_be_n[k]` low. A halfword drives `bus_be_n[1:0]` low when address bit 1 is 0, and `bus_be_n[3:2]` low otherwise. A word drives all four low. Outside a data phase, `bus_be_n` is 4'hF.
- R3: In 16-bit mode, `bus_be_n[3]` carries address bit 1 (active high). `bus_be_n[0]` is the low-byte select. `bus_be_n[2]` is the high-byte select, and `bus_be_n[1]` copies it. A byte at an even address drives only `bus_be_n[0]` low. A byte at an odd address drives only `bus_be_n[2:1]` low. A halfword or word drives `bus_be_n[2:0]` low.
- R4: In 16-bit mode, `bus_doe[1]` (the enable for D16–D31) is 0 on every cycle, and `bus_dout[31:16]` is 0.
- R5: In 16-bit mode, a word becomes two data phases. The first has `bus_be_n[3]`=0 and carries write bits 15:0. The second has `bus_be_n[3]`=1 and carries bits 31:16. The read result is {second D15–D0, first D15–D0}.
- R6: In 32-bit mode, write data is copied across the lanes: a byte goes to all four lanes, a halfword to both halves, and a word is sent as is. In 16-bit mode, a byte goes to both bytes of D15–D0 and a halfword goes to D15–D0.
- R7: Read data is returned zero-extended. In 32-bit mode it is taken from the lane selected by the low address bits. In 16-bit mode it is taken from D15–D0 (the high byte of D15–D0 for an odd byte address).
- R8: Each data phase holds `bus_cyc`, `bus_addr`, `bus_be_n` and `bus_dout` steady until `bus_ready` is sampled high at a rising clock edge.
- R9: `rsp_done` is a one-cycle pulse. It is visible in the cycle after the edge that sampled ready for the final phase, and `bus_cyc` is low by then.
- R10: An aligned request whose address has the top two bits `11` starts no data phase. It returns `rsp_done` in the next cycle with `rsp_err`=0 and `rsp_rdata`=0.
- R11: A halfword at an odd address, a word not on a 4-byte boundary, or size code 3 starts no data phase. It returns `rsp_done` with `rsp_err`=1 in the next cycle.
- R12: `bus_doe` is 2'b11 in a 32-bit write phase and 2'b00 in any read phase. `bus_write` follows the request direction. `bus_addr` equals request address bits 31:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; strap capture window |
| width_strap | input | 1 | 1 selects 16-bit bus |
| req_valid | input | 1 | One-cycle request strobe, taken when idle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Alignment error, with rsp_done |
| rsp_rdata | output | 32 | Zero-extended read data |
| bus_cyc | output | 1 | Data phase active |
| bus_write | output | 1 | Phase direction |
| bus_addr | output | 30 | Word address, bits 31:2 |
| bus_be_n | output | 4 | Byte selects / high-byte / A1 pins |
| bus_dout | output | 32 | Write data lines |
| bus_doe | output | 2 | Output enable, low and high 16 lines |
| bus_din | input | 32 | Read data lines |
| bus_ready | input | 1 | Ends the data phase when high at an edge |

## Verification
A wrong captured mode is visible in the first data phase after reset, because `bus_be_n[3]` and `bus_doe[1]` take values that cannot occur in the other mode. A stuck phase bit shows up in one of two ways: a 16-bit word that completes after one ready, or a second phase with the wrong A1 and the wrong half. Both are visible one cycle after the first ready. Errors in the request latch or the decode show up at once: a data phase where none should start, a missing completion pulse, or byte selects that disagree with the size and offset in the same cycle the phase begins.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
   localparam int BSZ_DW = 32;
   localparam int BSZ_LANES = BSZ_DW / 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;
endpackage

// File: rtl/bsz_strap_latch.sv
module bsz_strap_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_in,
   output logic mode16
);
   logic cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cap_q <= strap_in;
   end

   assign mode16 = cap_q;

   AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cap_q)); // R1
endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer
   import bsz_pkg::*;
(
   input  logic              mode16,
   input  logic              active,
   input  logic              write,
   input  xfer_size_e        size,
   input  logic [1:0]        alo,
   input  logic              phase,
   input  logic [BSZ_DW-1:0] wdata,
   input  logic [BSZ_DW-1:0] din,
   output logic [3:0]        be_n,
   output logic [BSZ_DW-1:0] dout,
   output logic [1:0]        doe,
   output logic [BSZ_DW-1:0] rd
);
   localparam int HW = BSZ_DW / 2;

   logic [BSZ_LANES-1:0] en32;
   logic [BSZ_DW-1:0]    dout32, dout16, rd32, rd16, sh8, sh16;
   logic [3:0]           be16;
   logic                 a1, lo_en, hi_en;

   for (genvar i = 0; i < BSZ_LANES; i++) begin : g_lane
      assign en32[i] = (size == SZ_BYTE) ? (alo == 2'(i)) :
                       (size == SZ_HALF) ? (alo[1] == 1'(i / 2)) : 1'b1;
      assign dout32[8*i +: 8] = (size == SZ_BYTE) ? wdata[7:0] :
                                (size == SZ_HALF) ? wdata[8*(i%2) +: 8] :
                                                    wdata[8*i +: 8];
   end

   assign a1    = (size == SZ_WORD) ? phase : alo[1];
   assign lo_en = (size != SZ_BYTE) || !alo[0];
   assign hi_en = (size != SZ_BYTE) ||  alo[0];
   assign be16  = {a1, !hi_en, !hi_en, !lo_en};

   assign dout16 = {{HW{1'b0}},
                    (size == SZ_BYTE)            ? {2{wdata[7:0]}} :
                    (size == SZ_WORD && phase)   ? wdata[BSZ_DW-1:HW] :
                                                   wdata[HW-1:0]};

   assign sh8  = din >> {alo, 3'b000};
   assign sh16 = din >> {alo[1], 4'b0000};
   assign rd32 = (size == SZ_BYTE) ? {24'h0, sh8[7:0]} :
                 (size == SZ_HALF) ? {{HW{1'b0}}, sh16[HW-1:0]} : din;
   assign rd16 = (size == SZ_BYTE) ? {24'h0, alo[0] ? din[15:8] : din[7:0]} :
                                     {{HW{1'b0}}, din[HW-1:0]};

   assign be_n = !active ? 4'hF : (mode16 ? be16 : ~en32);
   assign dout = mode16 ? dout16 : dout32;
   assign doe  = (active && write) ? (mode16 ? 2'b01 : 2'b11) : 2'b00;
   assign rd   = mode16 ? rd16 : rd32;
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
   import bsz_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IO_TAG_W = 2,
   parameter logic [IO_TAG_W-1:0] IO_TAG = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode16,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  xfer_size_e        req_size,
   input  logic              req_write,
   input  logic [BSZ_DW-1:0] req_wdata,
   input  logic              bus_ready,
   input  logic [BSZ_DW-1:0] lane_rd,
   output logic              active,
   output logic              phase,
   output logic [ADDR_W-1:0] addr_q,
   output xfer_size_e        size_q,
   output logic              wr_q,
   output logic [BSZ_DW-1:0] wdata_q,
   output logic              done_q,
   output logic              err_q,
   output logic [BSZ_DW-1:0] rdata_q
);
   localparam int HW = BSZ_DW / 2;

   typedef enum logic {ST_IDLE, ST_DATA} st_e;
   st_e st;
   logic [HW-1:0] low_q;
   logic misal, io_hit, split;

   assign misal  = (req_size == SZ_RSVD) ||
                   (req_size == SZ_HALF && req_addr[0]) ||
                   (req_size == SZ_WORD && req_addr[1:0] != 2'b00);
   assign io_hit = req_addr[ADDR_W-1 -: IO_TAG_W] == IO_TAG;
   assign split  = mode16 && (size_q == SZ_WORD);
   assign active = (st == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         phase   <= 1'b0;
         addr_q  <= '0;
         size_q  <= SZ_BYTE;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
         low_q   <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               size_q  <= req_size;
               wr_q    <= req_write;
               wdata_q <= req_wdata;
               phase   <= 1'b0;
               if (misal || io_hit) begin
                  done_q  <= 1'b1;
                  err_q   <= misal;
                  rdata_q <= '0;
               end else begin
                  st <= ST_DATA;
               end
            end
            ST_DATA: if (bus_ready) begin
               if (split && !phase) begin
                  phase <= 1'b1;
                  low_q <= lane_rd[HW-1:0];
               end else begin
                  st      <= ST_IDLE;
                  done_q  <= 1'b1;
                  rdata_q <= split ? {lane_rd[HW-1:0], low_q} : lane_rd;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (active && split && !phase && bus_ready) |=> (active && phase)); // R5
   AST_SKIP_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && req_valid && (misal || io_hit)) |=> (!active && done_q)); // R10
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> done_q); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !active); // R9
endmodule

// File: rtl/bsz_bus_sizer.sv
module bsz_bus_sizer
   import bsz_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IO_TAG_W = 2,
   parameter logic [IO_TAG_W-1:0] IO_TAG = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              width_strap,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [31:0]       req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              bus_cyc,
   output logic              bus_write,
   output logic [ADDR_W-3:0] bus_addr,
   output logic [3:0]        bus_be_n,
   output logic [31:0]       bus_dout,
   output logic [1:0]        bus_doe,
   input  logic [31:0]       bus_din,
   input  logic              bus_ready
);
   if (ADDR_W < IO_TAG_W + 3 || ADDR_W > 64) begin : g_bad_addr_w
      $error("bsz_bus_sizer: ADDR_W out of range");
   end
   if (IO_TAG_W < 1) begin : g_bad_tag_w
      $error("bsz_bus_sizer: IO_TAG_W must be at least 1");
   end
   if (BSZ_DW != 32) begin : g_bad_dw
      $error("bsz_bus_sizer: internal port must be 32 bits");
   end

   logic              mode16, active, phase, wr_q;
   logic [ADDR_W-1:0] addr_q;
   xfer_size_e        size_q;
   logic [31:0]       wdata_q, lane_rd;

   bsz_strap_latch u_strap (
      .clk(clk), .rst_n(rst_n), .strap_in(width_strap), .mode16(mode16)
   );

   bsz_seq #(.ADDR_W(ADDR_W), .IO_TAG_W(IO_TAG_W), .IO_TAG(IO_TAG)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode16(mode16),
      .req_valid(req_valid), .req_addr(req_addr),
      .req_size(xfer_size_e'(req_size)), .req_write(req_write),
      .req_wdata(req_wdata), .bus_ready(bus_ready), .lane_rd(lane_rd),
      .active(active), .phase(phase), .addr_q(addr_q), .size_q(size_q),
      .wr_q(wr_q), .wdata_q(wdata_q), .done_q(rsp_done), .err_q(rsp_err),
      .rdata_q(rsp_rdata)
   );

   bsz_lane_steer u_steer (
      .mode16(mode16), .active(active), .write(wr_q), .size(size_q),
      .alo(addr_q[1:0]), .phase(phase), .wdata(wdata_q), .din(bus_din),
      .be_n(bus_be_n), .dout(bus_dout), .doe(bus_doe), .rd(lane_rd)
   );

   assign bus_cyc   = active;
   assign bus_write = wr_q;
   assign bus_addr  = addr_q[ADDR_W-1:2];

   AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) &&
                                   $stable(bus_be_n) && $stable(bus_dout))); // R8
   AST_UPPER_LINES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode16 && bus_cyc) |-> (!bus_doe[1] && bus_dout[31:16] == 16'h0)); // R4
   AST_BYTE_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !mode16 && size_q == SZ_BYTE) |-> $countones(~bus_be_n) == 1); // R2
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_write) |-> bus_doe == 2'b00); // R12
endmodule

// File: tb/bsz_bus_sizer_tb_top.sv
module bsz_bus_sizer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        width_strap = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done, rsp_err, bus_cyc, bus_write;
   logic [31:0] rsp_rdata, bus_dout;
   logic [29:0] bus_addr;
   logic [3:0]  bus_be_n;
   logic [1:0]  bus_doe;
   logic [31:0] bus_din = '0;
   logic        bus_ready = 1'b0;

   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   bsz_bus_sizer dut_i (
      .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
      .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
      .req_write(req_write), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_cyc(bus_cyc), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_be_n(bus_be_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din), .bus_ready(bus_ready)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(bit m16, logic [1:0] sz, logic [1:0] a, bit p);
      logic [3:0] e;
      if (!m16) begin
         if (sz == 2'd0)      e = ~(4'b0001 << a);
         else if (sz == 2'd1) e = ~(4'b0011 << {a[1], 1'b0});
         else                 e = 4'b0000;
      end else begin
         bit a1 = (sz == 2'd2) ? p : a[1];
         bit lo = (sz != 2'd0) || !a[0];
         bit hi = (sz != 2'd0) || a[0];
         e = {a1, !hi, !hi, !lo};
      end
      return e;
   endfunction

   function automatic logic [31:0] exp_dout(bit m16, logic [1:0] sz, logic [31:0] w, bit p);
      if (!m16) return (sz == 2'd0) ? {4{w[7:0]}} : (sz == 2'd1) ? {2{w[15:0]}} : w;
      return (sz == 2'd0) ? {16'h0, {2{w[7:0]}}} :
             (sz == 2'd2 && p) ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
   endfunction

   function automatic logic [31:0] din_for(logic [31:0] a, int p);
      return 32'h8E4B_27D1 + 32'(p) * 32'h0101_0101 + a;
   endfunction

   function automatic logic [31:0] exp_rd(bit m16, logic [1:0] sz, logic [31:0] a);
      logic [31:0] d0 = din_for(a, 0);
      logic [31:0] d1 = din_for(a, 1);
      if (!m16) begin
         if (sz == 2'd0) return {24'h0, 8'(d0 >> (8 * int'(a[1:0])))};
         if (sz == 2'd1) return {16'h0, 16'(d0 >> (16 * int'(a[1])))};
         return d0;
      end
      if (sz == 2'd0) return {24'h0, a[0] ? d0[15:8] : d0[7:0]};
      if (sz == 2'd1) return {16'h0, d0[15:0]};
      return {d1[15:0], d0[15:0]};
   endfunction

   task automatic do_reset(input bit strap);
      @(negedge clk);
      rst_n = 1'b0;
      width_strap = strap;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_be_n == 4'hF && !bus_cyc && !rsp_done, "R2 idle after reset",
          {27'h0, bus_cyc, bus_be_n}, 32'hF);
   endtask

   task automatic issue(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                        input logic [31:0] w);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = w;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic xfer(input bit m16, input logic [31:0] a, input logic [1:0] sz,
                       input bit wr, input logic [31:0] w, input int waits);
      int nph = (m16 && sz == 2'd2) ? 2 : 1;
      string btag = m16 ? "R3 select pins" : "R2 byte selects";
      issue(a, sz, wr, w);
      for (int p = 0; p < nph; p++) begin
         logic [3:0] eb = exp_be(m16, sz, a[1:0], p[0]);
         logic [31:0] ed = exp_dout(m16, sz, w, p[0]);
         logic [1:0] eo = wr ? (m16 ? 2'b01 : 2'b11) : 2'b00;
         chk(bus_cyc == 1'b1, "R8 phase active", {31'h0, bus_cyc}, 32'h1);
         chk(bus_be_n == eb, btag, {28'h0, bus_be_n}, {28'h0, eb});
         if (m16 && sz == 2'd2)
            chk(bus_be_n[3] == p[0], "R5 A1 per phase", {31'h0, bus_be_n[3]}, {31'h0, p[0]});
         chk(bus_addr == a[31:2] && bus_write == wr, "R12 address and direction",
             {bus_addr, 1'b0, bus_write}, {a[31:2], 1'b0, wr});
         chk(bus_doe == eo, m16 ? "R4 lane enables" : "R12 lane enables",
             {30'h0, bus_doe}, {30'h0, eo});
         if (wr) chk(bus_dout == ed, m16 ? "R5 R6 write lanes" : "R6 write lanes", bus_dout, ed);
         if (m16) chk(bus_dout[31:16] == 16'h0 && !bus_doe[1], "R4 upper lines idle",
                      bus_dout, {16'h0, bus_dout[15:0]});
         for (int k = 0; k < waits; k++) begin
            bus_ready = 1'b0;
            @(negedge clk);
            chk(bus_cyc && bus_be_n == eb && !rsp_done, "R8 hold during wait",
                {27'h0, rsp_done, bus_be_n}, {28'h0, eb});
         end
         bus_ready = 1'b1;
         bus_din = din_for(a, p);
         @(negedge clk);
         bus_ready = 1'b0;
         bus_din = 32'hDEAD_BEEF;
      end
      chk(rsp_done && !rsp_err && !bus_cyc, "R9 done after final phase",
          {29'h0, rsp_done, rsp_err, bus_cyc}, 32'h4);
      if (!wr) begin
         logic [31:0] er = exp_rd(m16, sz, a);
         chk(rsp_rdata == er, m16 ? "R7 R5 read data" : "R7 read data", rsp_rdata, er);
      end
      @(negedge clk);
      chk(!rsp_done, "R9 done is one cycle", {31'h0, rsp_done}, 32'h0);
   endtask

   task automatic no_bus(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                         input bit exp_err, input string tag);
      issue(a, sz, wr, 32'hFFFF_FFFF);
      chk(rsp_done && rsp_err == exp_err && !bus_cyc && bus_be_n == 4'hF, tag,
          {26'h0, rsp_done, rsp_err, bus_cyc, 1'b0, bus_be_n[1:0]},
          {26'h0, 1'b1, exp_err, 1'b0, 1'b0, 2'b11});
      if (!exp_err) chk(rsp_rdata == 32'h0, "R10 zero data", rsp_rdata, 32'h0);
      @(negedge clk);
      chk(!rsp_done && !bus_cyc, tag, {30'h0, rsp_done, bus_cyc}, 32'h0);
   endtask

   task automatic sweep(input bit m16);
      for (int sz = 0; sz < 3; sz++)
         for (int lo = 0; lo < 4; lo++)
            for (int wr = 0; wr < 2; wr++) begin
               logic [31:0] a = 32'h0000_1230 + 32'(lo) + 32'(sz * 64);
               logic [31:0] w = 32'h1357_9BDF ^ (a << 4) ^ 32'(wr * 32'h0F0F_0000);
               bit bad = (sz == 1 && lo[0]) || (sz == 2 && lo != 0);
               if (bad) no_bus(a, 2'(sz), wr[0], 1'b1, "R11 misaligned");
               else xfer(m16, a, 2'(sz), wr[0], w, (sz + lo + wr) % 3);
            end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // 32-bit mode
      do_reset(1'b0);
      sweep(1'b0);
      no_bus(32'hC000_0000, 2'd2, 1'b0, 1'b0, "R10 io window read");
      no_bus(32'hFFFF_FFFC, 2'd2, 1'b1, 1'b0, "R10 io window write");
      no_bus(32'h0000_2000, 2'd3, 1'b0, 1'b1, "R11 size code 3");
      no_bus(32'hC000_0002, 2'd2, 1'b0, 1'b1, "R11 misaligned io");
      // R1: strap change after reset must not switch to 16-bit
      width_strap = 1'b1;
      repeat (2) @(negedge clk);
      xfer(1'b0, 32'h0000_0402, 2'd1, 1'b0, 32'h0, 0);
      chk(1'b1, "R1 strap ignored 32", 32'h0, 32'h0);
      xfer(1'b0, 32'h0000_0410, 2'd2, 1'b1, 32'hA5A5_5A5A, 1);

      // 16-bit mode
      do_reset(1'b1);
      sweep(1'b1);
      no_bus(32'hE000_1000, 2'd1, 1'b1, 1'b0, "R10 io window 16");
      // R1: strap dropped after reset keeps 16-bit mode
      width_strap = 1'b0;
      repeat (2) @(negedge clk);
      xfer(1'b1, 32'h0000_0802, 2'd1, 1'b1, 32'h0000_C0DE, 0);
      xfer(1'b1, 32'h0000_0804, 2'd2, 1'b0, 32'h0, 2);
      chk(1'b1, "R1 strap ignored 16", 32'h0, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule